// File: doc/BRIEF.md
# Linked-List Descriptor Autoload Front End

This block sits in front of a single DMA channel and loads that channel's transfer parameters out of memory. It works through a chain of descriptors. The chain starts at a next-descriptor pointer that software programs. Every descriptor begins with two header words. The first header word links to the following descriptor and carries a pause flag in bit 0. The second header word holds the element count of the current node. It also describes the shape of the node that comes next: its type, which of its addresses are valid, and whether that node raises a block-end notice when it completes. Because of this, the number of words fetched and the working registers written change from node to node. Every word not yet loaded keeps the value it had before.

Once a node is loaded, the block starts one block transfer through a start/done handshake with the transfer engine. When the engine reports done, the block does one of three things: it fetches the next node, halts in a paused state, or signals that the list has ended. Software has a small register window. It holds the control word, the next-descriptor pointer, a count of finished nodes and a read-only capability word. In fast mode the first descriptor is fetched before any transfer starts. Without fast mode, the transfer already held in the working registers runs first.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, register 0 (control) and register 2 (node count) read 0, and register 3 reads 0x0010_0000 (bit 20: list mode supported). No memory request, transfer start or list-done is active. The control word keeps only bits 0 (first node destination valid), 2 (first node source valid), 5:4 (first node type), 7 (paused), 8 (list mode enable) and 10 (fast mode).
- R2: A write to register 0 that raises bit 8 from 0 to 1 sets the working frame count to 0xFFFF and the working element count to 0xFFFFFF.
- R3: A channel enable with list mode on, bit 7 clear and fast mode set fetches the node at the programmed pointer before the first transfer start. The type and valid flags of that node come from control bits 5:4, 2 and 0.
- R4: With fast mode clear, an enable first issues one transfer start with the working registers unchanged and no memory read. Only after that transfer's done does the first node get fetched.
- R5: Descriptor word 0 is the next-node pointer, with the pause flag in bit 0 and the address being the word with bits 1:0 cleared. Word 1 bits 23:0 load the working element count. Word 1 bits 31:29 give the following node's type, bit 24 its source valid flag, bit 26 its destination valid flag and bit 28 its block-end request.
- R6: A node is read as consecutive words from its base, with mem_req and mem_addr held until mem_rvalid. The word count is 12 for type 1. For type 2 it is 8 when both valid flags are set, otherwise 7. For type 3 it is 4 when both flags are set, otherwise 3.
- R7: After the two header words, a two-address node carries, in order: source, destination, a frame word (bits 15:0 frame count, 31:16 interrupt control), an index word (bits 15:0 source element index, 31:16 destination element index), destination frame index, source frame index, then for type 1 only color, data-parameter, link-control and channel-control. A single-address node carries one address word followed by the same sequence from the frame word on. Registers a node does not carry keep their values.
- R8: An address word is written to the source register only when the node's source flag is set, and to the destination register only when its destination flag is set. For a single-address node, the one address goes to whichever register is flagged.
- R9: When a node's done arrives and its next pointer address is 0xFFFF_FFFC, the block pulses list_done and issues no further memory request. An enable in that state finishes with list_done at once and no fetch.
- R10: When a node whose pause flag is set completes, control bit 7 is set and the block halts. An enable is ignored while bit 7 is set. After software clears bit 7 and enables, fetching continues at the next node.
- R11: Register 2 counts finished descriptors, modulo 2^16. The programmed (non-list) transfer is not counted. Writing 0 to register 2 clears it, and writing any other value leaves it unchanged.
- R12: blk_end pulses for one cycle after the done of a node whose block-end request was set by the previous node's header. The first node never requests it.
- R13: A node type code other than 1, 2 or 3 fetches only the two header words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 next pointer, 2 node count, 3 capability |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ch_enable | input | 1 | One-cycle channel enable / resume pulse |
| mem_req | output | 1 | Word read request, held until mem_rvalid |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle start of a block transfer |
| xfer_done | input | 1 | Block transfer finished |
| list_done | output | 1 | One-cycle pulse at end of list |
| blk_end | output | 1 | One-cycle block-end notification |
| w_src | output | 32 | Working source address |
| w_dst | output | 32 | Working destination address |
| w_elem | output | 24 | Working element count |
| w_frames | output | 16 | Working frame count |
| w_irqctl | output | 16 | Working interrupt control |
| w_deidx | output | 16 | Working destination element index |
| w_seidx | output | 16 | Working source element index |
| w_dfidx | output | 32 | Working destination frame index / packet size |
| w_sfidx | output | 32 | Working source frame index / packet size |
| w_color | output | 32 | Working color word |
| w_csdp | output | 32 | Working data-parameter word |
| w_lnk | output | 32 | Working link-control word |
| w_ccr | output | 32 | Working channel-control word |

## Verification
The bench targets the points where the type of one node is carried in the header of the node before it. It mixes all five node shapes in random order, so a loader that decoded the type from the wrong header would read the wrong number of words and fill the wrong registers. Single-address nodes with only one flag set, or with neither, catch a design that writes the lone address to both registers or overwrites the unflagged one. Directed cases cover an empty list in both start modes, a pause on the last node (the resume must end the list with no fetch), an enable while still paused (a careless design would restart), the header-only node shape, and count writes of zero and non-zero.

// File: rtl/dma_desc_loader.sv
module dma_desc_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ch_enable,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        xfer_start,
  input  logic        xfer_done,
  output logic        list_done,
  output logic        blk_end,
  output logic [31:0] w_src,
  output logic [31:0] w_dst,
  output logic [23:0] w_elem,
  output logic [15:0] w_frames,
  output logic [15:0] w_irqctl,
  output logic [15:0] w_deidx,
  output logic [15:0] w_seidx,
  output logic [31:0] w_dfidx,
  output logic [31:0] w_sfidx,
  output logic [31:0] w_color,
  output logic [31:0] w_csdp,
  output logic [31:0] w_lnk,
  output logic [31:0] w_ccr
);
  localparam logic [31:0] END_PTR  = 32'hFFFF_FFFC;
  localparam logic [31:0] CTL_MASK = 32'h0000_05B5;
  localparam logic [31:0] CAPS     = 32'h0010_0000;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_PAUSE} st_t;
  st_t st;

  logic [31:0] ctl, nxt, base;
  logic [15:0] cnt;
  logic [3:0]  widx, flen, slot;
  logic [2:0]  cur_t, nt;
  logic        cur_sv, cur_dv, cur_blk, nsv, ndv, nblk, initx;
  logic        two, nxt_end, last_word, go, advance;

  assign two       = (cur_t == 3'd1) || (cur_sv && cur_dv);
  assign slot      = two ? (widx - 4'd2) : (widx - 4'd1);
  assign nxt_end   = ({nxt[31:2], 2'b00} == END_PTR);
  assign last_word = (widx == flen - 4'd1);
  assign go        = ch_enable && ctl[8] && !ctl[7];
  assign advance   = (st == S_IDLE && go && ctl[10]) ||
                     (st == S_XFER && xfer_done && (initx || !nxt[0])) ||
                     (st == S_PAUSE && go);
  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = base + {26'd0, widx, 2'b00};

  always_comb begin
    case (cur_t)
      3'd1:    flen = 4'd12;
      3'd2:    flen = two ? 4'd8 : 4'd7;
      3'd3:    flen = two ? 4'd4 : 4'd3;
      default: flen = 4'd2;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl;
      2'd1:    reg_rdata = nxt;
      2'd2:    reg_rdata = {16'd0, cnt};
      default: reg_rdata = CAPS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctl <= '0; nxt <= '0; base <= '0; cnt <= '0; widx <= '0;
      cur_t <= '0; cur_sv <= 1'b0; cur_dv <= 1'b0; cur_blk <= 1'b0;
      nt <= '0; nsv <= 1'b0; ndv <= 1'b0; nblk <= 1'b0; initx <= 1'b0;
      xfer_start <= 1'b0; list_done <= 1'b0; blk_end <= 1'b0;
      w_src <= '0; w_dst <= '0; w_elem <= '0; w_frames <= '0; w_irqctl <= '0;
      w_deidx <= '0; w_seidx <= '0; w_dfidx <= '0; w_sfidx <= '0;
      w_color <= '0; w_csdp <= '0; w_lnk <= '0; w_ccr <= '0;
    end else begin
      xfer_start <= 1'b0;
      list_done  <= 1'b0;
      blk_end    <= 1'b0;

      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            ctl <= reg_wdata & CTL_MASK;
            if (reg_wdata[8] && !ctl[8]) begin
              w_frames <= 16'hFFFF;
              w_elem   <= 24'hFF_FFFF;
            end
          end
          2'd1: nxt <= reg_wdata;
          2'd2: if (reg_wdata == 32'd0) cnt <= '0;
          default: ;
        endcase
      end

      if (advance) begin
        if (nxt_end) begin
          list_done <= 1'b1;
          st <= S_IDLE;
        end else begin
          base <= {nxt[31:2], 2'b00};
          widx <= '0;
          st   <= S_FETCH;
        end
      end

      case (st)
        S_IDLE: if (go) begin
          cur_t   <= {1'b0, ctl[5:4]};
          cur_sv  <= ctl[2];
          cur_dv  <= ctl[0];
          cur_blk <= 1'b0;
          if (!ctl[10]) begin
            st <= S_XFER;
            xfer_start <= 1'b1;
            initx <= 1'b1;
          end
        end
        S_FETCH: if (mem_rvalid) begin
          if (widx == 4'd0) nxt <= mem_rdata;
          else if (widx == 4'd1) begin
            w_elem <= mem_rdata[23:0];
            nt     <= mem_rdata[31:29];
            nsv    <= mem_rdata[24];
            ndv    <= mem_rdata[26];
            nblk   <= mem_rdata[28];
          end else if (!two && widx == 4'd2) begin
            if (cur_sv) w_src <= mem_rdata;
            if (cur_dv) w_dst <= mem_rdata;
          end else begin
            case (slot)
              4'd0: if (cur_sv) w_src <= mem_rdata;
              4'd1: if (cur_dv) w_dst <= mem_rdata;
              4'd2: {w_irqctl, w_frames} <= mem_rdata;
              4'd3: {w_deidx, w_seidx} <= mem_rdata;
              4'd4: w_dfidx <= mem_rdata;
              4'd5: w_sfidx <= mem_rdata;
              4'd6: w_color <= mem_rdata;
              4'd7: w_csdp  <= mem_rdata;
              4'd8: w_lnk   <= mem_rdata;
              4'd9: w_ccr   <= mem_rdata;
              default: ;
            endcase
          end
          if (last_word) begin
            st <= S_XFER;
            xfer_start <= 1'b1;
          end else begin
            widx <= widx + 4'd1;
          end
        end
        S_XFER: if (xfer_done) begin
          initx <= 1'b0;
          if (!initx) begin
            cnt     <= cnt + 16'd1;
            blk_end <= cur_blk;
            cur_t   <= nt;
            cur_sv  <= nsv;
            cur_dv  <= ndv;
            cur_blk <= nblk;
            if (nxt[0]) begin
              ctl[7] <= 1'b1;
              st <= S_PAUSE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_loader_chk.sv
module dma_desc_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        xfer_start,
  input logic        xfer_done,
  input logic        list_done,
  input logic        blk_end,
  input logic        in_pause,
  input logic [15:0] cnt
);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  a_r9_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> (!mem_req && !xfer_start));

  a_r10_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (!mem_req && !xfer_start));

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 16'd1) || (cnt == 16'd0)));

  a_r12_blk_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> $past(xfer_done));
endmodule

bind dma_desc_loader dma_desc_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .xfer_start(xfer_start), .xfer_done(xfer_done),
  .list_done(list_done), .blk_end(blk_end), .in_pause(st == S_PAUSE),
  .cnt(cnt)
);

// File: tb/tb_dma_desc_loader.sv
module tb_dma_desc_loader;
  localparam logic [31:0] END_PTR = 32'hFFFF_FFFC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ch_enable = 1'b0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic xfer_start, xfer_done = 1'b0, list_done, blk_end;
  logic [31:0] w_src, w_dst, w_dfidx, w_sfidx, w_color, w_csdp, w_lnk, w_ccr;
  logic [23:0] w_elem;
  logic [15:0] w_frames, w_irqctl, w_deidx, w_seidx;

  dma_desc_loader dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, beats = 0;
  bit finished = 0;
  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[11:2]];
    if (mem_rvalid) beats <= beats + 1;
  end

  logic [31:0] e_src = 0, e_dst = 0, e_dfi = 0, e_sfi = 0, e_col = 0, e_csdp = 0, e_lnk = 0, e_ccr = 0;
  logic [23:0] e_elem = 0;
  logic [15:0] e_frm = 0, e_irq = 0, e_dei = 0, e_sei = 0;
  int ty [8];
  bit sv [8], dv [8], bk [8], ps [8];
  int acc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbase(input int i);
    return 32'h100 + i * 64;
  endfunction

  function automatic int flen(input int t, input bit s, input bit d);
    bit two = (t == 1) || (s && d);
    case (t)
      1: return 12;
      2: return two ? 8 : 7;
      3: return two ? 4 : 3;
      default: return 2;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata; reg_addr = 2'd0; #1;
  endtask

  task automatic pulse_en();
    @(negedge clk); ch_enable = 1'b1;
    @(negedge clk); ch_enable = 1'b0;
  endtask

  task automatic write_node(input int i, input int n);
    int b = nbase(i) >> 2;
    logic [31:0] w;
    w = (i == n - 1) ? END_PTR : 32'(nbase(i + 1));
    w[0] = ps[i];
    mem[b] = w;
    w = {8'h00, 24'($urandom)};
    if (i < n - 1) begin
      w[31:29] = 3'(ty[i + 1]); w[24] = sv[i + 1]; w[26] = dv[i + 1]; w[28] = bk[i + 1];
    end
    mem[b + 1] = w;
    for (int j = 2; j < 12; j++) mem[b + j] = $urandom;
  endtask

  task automatic build(input int n, input bit allow_pause);
    for (int i = 0; i < n; i++) begin
      int f = $urandom_range(0, 4);
      int r = $urandom_range(0, 2);
      case (f)
        0: begin ty[i] = 1; sv[i] = 1'($urandom); dv[i] = 1'($urandom); end
        1: begin ty[i] = 2; sv[i] = 1; dv[i] = 1; end
        2: begin ty[i] = 2; sv[i] = (r == 0); dv[i] = (r == 1); end
        3: begin ty[i] = 3; sv[i] = 1; dv[i] = 1; end
        default: begin ty[i] = 3; sv[i] = (r == 0); dv[i] = (r == 1); end
      endcase
      bk[i] = (i == 0) ? 1'b0 : 1'($urandom);
      ps[i] = allow_pause && ($urandom_range(0, 3) == 0);
    end
    for (int i = 0; i < n; i++) write_node(i, n);
  endtask

  task automatic upd(input int i);
    int b = nbase(i) >> 2;
    bit two = (ty[i] == 1) || (sv[i] && dv[i]);
    int len = flen(ty[i], sv[i], dv[i]);
    logic [31:0] w;
    e_elem = mem[b + 1][23:0];
    for (int j = 2; j < len; j++) begin
      w = mem[b + j];
      if (!two && j == 2) begin
        if (sv[i]) e_src = w;
        if (dv[i]) e_dst = w;
      end else begin
        case (two ? j - 2 : j - 1)
          0: if (sv[i]) e_src = w;
          1: if (dv[i]) e_dst = w;
          2: begin e_frm = w[15:0]; e_irq = w[31:16]; end
          3: begin e_sei = w[15:0]; e_dei = w[31:16]; end
          4: e_dfi = w;
          5: e_sfi = w;
          6: e_col = w;
          7: e_csdp = w;
          8: e_lnk = w;
          default: e_ccr = w;
        endcase
      end
    end
  endtask

  task automatic check_regs();
    chk(w_src == e_src, "R8 source address register", w_src, e_src);
    chk(w_dst == e_dst, "R8 destination address register", w_dst, e_dst);
    chk(w_elem == e_elem, "R5 element count", 32'(w_elem), 32'(e_elem));
    chk({w_irqctl, w_frames} == {e_irq, e_frm}, "R7 frame word", {w_irqctl, w_frames}, {e_irq, e_frm});
    chk({w_deidx, w_seidx} == {e_dei, e_sei}, "R7 index word", {w_deidx, w_seidx}, {e_dei, e_sei});
    chk(w_dfidx == e_dfi && w_sfidx == e_sfi, "R7 frame indices", w_dfidx ^ w_sfidx, e_dfi ^ e_sfi);
    chk(w_color == e_col && w_csdp == e_csdp, "R7 color and data-parameter", w_color ^ w_csdp, e_col ^ e_csdp);
    chk(w_lnk == e_lnk && w_ccr == e_ccr, "R7 link and channel control", w_lnk ^ w_ccr, e_lnk ^ e_ccr);
  endtask

  task automatic run_list(input int n, input bit fast, input logic [31:0] head);
    logic [31:0] ctl_v, v;
    int k, b0, guard;
    bit fin;
    rd(2'd2, v);
    chk(v == 32'(acc), "R11 count before list", v, 32'(acc));
    wr(2'd2, 32'd7);
    rd(2'd2, v);
    chk(v == 32'(acc), "R11 non-zero write ignored", v, 32'(acc));
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    chk(v == 32'd0, "R11 zero write clears", v, 32'd0);
    acc = 0;
    wr(2'd0, 32'd0);
    wr(2'd1, head);
    ctl_v = 32'h100;
    ctl_v[10] = fast;
    if (n > 0) begin ctl_v[5:4] = 2'(ty[0]); ctl_v[2] = sv[0]; ctl_v[0] = dv[0]; end
    else ctl_v[5:4] = 2'd1;
    wr(2'd0, ctl_v);
    e_frm = 16'hFFFF; e_elem = 24'hFF_FFFF;
    chk(w_frames == 16'hFFFF, "R2 frame count marker", 32'(w_frames), 32'hFFFF);
    chk(w_elem == 24'hFF_FFFF, "R2 element count marker", 32'(w_elem), 32'hFF_FFFF);
    k = fast ? 0 : -1;
    b0 = beats;
    guard = 0;
    pulse_en();
    fin = list_done;
    while (!fin && guard < 20000) begin
      guard++;
      if (xfer_start) begin
        if (k < 0) begin
          chk(beats == b0, "R4 no fetch before programmed transfer", 32'(beats - b0), 0);
          check_regs();
        end else begin
          upd(k);
          if (fast && k == 0)
            chk(beats > b0, "R3 first node fetched before first transfer", 32'(beats - b0), 32'(flen(ty[0], sv[0], dv[0])));
          if (ty[k] == 0)
            chk(beats - b0 == 2, "R13 header-only fetch", 32'(beats - b0), 2);
          else
            chk(beats - b0 == flen(ty[k], sv[k], dv[k]), "R6 words fetched per node", 32'(beats - b0), 32'(flen(ty[k], sv[k], dv[k])));
          check_regs();
        end
        b0 = beats;
        repeat (2) @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        if (k >= 0) begin
          acc++;
          chk(blk_end == bk[k], "R12 block-end notification", 32'(blk_end), 32'(bk[k]));
          if (ps[k]) begin
            chk(reg_rdata[7] == 1'b1, "R10 paused bit set", 32'(reg_rdata[7]), 1);
            pulse_en();
            repeat (4) @(negedge clk);
            chk(beats == b0 && reg_rdata[7] && !list_done, "R10 enable ignored while paused", 32'(beats - b0), 0);
            wr(2'd0, ctl_v);
            pulse_en();
          end
        end
        k++;
        if (list_done) fin = 1;
      end else begin
        @(negedge clk);
        if (list_done) fin = 1;
      end
    end
    chk(fin && k == n, "R9 list ends after last node", 32'(k), 32'(n));
    chk(beats == b0, "R9 no fetch at end of list", 32'(beats - b0), 0);
    rd(2'd2, v);
    chk(v == 32'(acc), "R11 finished-node count", v, 32'(acc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk(v == 32'd0, "R1 control reset", v, 0);
    rd(2'd2, v); chk(v == 32'd0, "R1 count reset", v, 0);
    rd(2'd3, v); chk(v == 32'h0010_0000, "R1 capability word", v, 32'h0010_0000);
    chk(!mem_req && !xfer_start && !list_done, "R1 idle outputs", {29'd0, mem_req, xfer_start, list_done}, 0);
    wr(2'd0, 32'hFFFF_FFFF & ~32'h100 & ~32'h80);
    rd(2'd0, v); chk(v == 32'h0000_0435, "R1 control keeps defined bits", v, 32'h0000_0435);
    wr(2'd0, 32'd0);

    run_list(0, 1'b1, END_PTR);
    run_list(0, 1'b0, END_PTR);

    ty[0] = 0; sv[0] = 0; dv[0] = 0; bk[0] = 0; ps[0] = 0;
    write_node(0, 1);
    run_list(1, 1'b1, 32'(nbase(0)));

    for (int i = 0; i < 5; i++) begin
      ty[i] = (i == 0) ? 1 : (i < 3 ? 2 : 3);
      sv[i] = (i != 2 && i != 4) ? 1'b1 : 1'b0;
      dv[i] = (i == 0 || i == 1 || i == 2 || i == 3) ? 1'b1 : 1'b0;
      bk[i] = (i == 2);
      ps[i] = (i == 1 || i == 4);
    end
    for (int i = 0; i < 5; i++) write_node(i, 5);
    run_list(5, 1'b0, 32'(nbase(0)));

    for (int r = 0; r < 10; r++) begin
      int n = $urandom_range(3, 8);
      build(n, 1'b1);
      run_list(n, 1'($urandom), 32'(nbase(0)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule